// File: doc/BRIEF.md
# Flash Completion Poller

This block sits on the host side of an asynchronous parallel NOR flash. It takes one write request, made of an operation, a target address and a data word. It plays out the unlock and command bus writes that the operation needs. It then reads the target location over and over until the flash reports that its internal program or erase has finished. The outcome is returned as a single-cycle done or error pulse.

Each request selects how completion is judged. In bit-7 polling, the poller compares bit 7 of the status word with the value the finished operation would leave there. In toggle polling, it watches whether bit 6 keeps flipping between consecutive reads. Completion inside the flash is not synchronous to the host, so a read that claims completion is never trusted alone. The poller follows it with two confirming reads of the full word. An operation that does not finish within its cycle budget is reported as an error, and the poller then sends the return-to-read command.

Every bus cycle, read or write, has the same shape: a setup phase with chip enable low, a strobe phase with the write or output strobe low, and a hold phase. Each phase has its own parameterised length in clock cycles.

Top module: `fpoll_ctrl`

## Requirements
- R1: A program request (op code 0) issues exactly four bus writes, given here as (address, data): (5555h, AAh), (2AAAh, 55h), (5555h, A0h), then (target address, request data).
- R2: An erase request issues exactly six bus writes. The first five are (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h). The sixth depends on the op code: sector erase (op code 1) writes (target, 30h), block erase (op code 2) writes (target, 50h), and chip erase (op code 3) writes (5555h, 10h).
- R3: With req_toggle=0 (bit-7 polling), a status read shows completion when bit 7 equals bit 7 of the request data for a program, or when bit 7 is 1 for any erase.
- R4: With req_toggle=1 (toggle polling), a status read shows completion when its bit 6 equals bit 6 of the status read just before it in the same operation. The first status read can never show completion.
- R5: After a status read that shows completion, exactly two more reads of the target follow. done_o pulses only if both reads return the expected word: the request data for a program, or FFFFh for an erase. Otherwise err_o pulses, no further bus cycle follows, and the poller returns to idle.
- R6: If a status read does not show completion and the polling cycle count has reached the timeout (PROG_TMO for a program, ERASE_TMO for an erase), err_o pulses. Three bus writes follow: (5555h, AAh), (2AAAh, 55h), (5555h, F0h). The poller then returns to idle.
- R7: In every bus cycle, chip enable stays low for T_SU+T_PW+T_HD clock cycles, and the active strobe is low for exactly T_PW of them. The write and output strobes are never low together. Neither strobe is low while chip enable is high. The data bus is driven during writes only. Address and write data stay constant while chip enable is low.
- R8: A request is taken only in a cycle where req_ready is 1. req_ready is 1 exactly when the poller is idle, and requests presented while it is busy have no effect.
- R9: Each operation ends with exactly one pulse, either done_o or err_o, one clock cycle wide. The two pulses are never high together.
- R10: During and after reset, req_ready is 1, all three strobes are high, fl_dq_oe is 0, and done_o and err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Poller idle; request taken this cycle if valid |
| req_op | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| req_addr | input | AW | Target word address |
| req_data | input | DW | Word to program |
| req_toggle | input | 1 | 0 bit-7 polling, 1 toggle polling |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | One-cycle failure pulse |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_oe_n | output | 1 | Flash output strobe, active low |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | DW | Write data toward the flash |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_out |
| fl_dq_in | input | DW | Read data from the flash |

## Verification
The hardest case to reach from the ports is a read that catches the flash at the moment it finishes. In that read, bit 7 or bit 6 already says done while the rest of the word is still wrong. The bench's flash model can make the first read after its busy period return a word with the status bits correct and two other bits flipped. The poller must treat that read as the completion signal and still finish with done, because the two reads that follow are clean. A second model setting keeps the final word wrong, to prove that rejection happens without the exit sequence. A third leaves the flash busy forever, to drive the timeout and exit writes.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_POLL,
    ST_VERIFY,
    ST_EXIT
  } st_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SU,
    PH_PW,
    PH_HD
  } ph_e;

  localparam logic [15:0] UNLK_A1 = 16'h5555;
  localparam logic [15:0] UNLK_A2 = 16'h2AAA;
  localparam logic [7:0]  CD_AA   = 8'hAA;
  localparam logic [7:0]  CD_55   = 8'h55;
  localparam logic [7:0]  CD_PROG = 8'hA0;
  localparam logic [7:0]  CD_ERS  = 8'h80;
  localparam logic [7:0]  CD_SECT = 8'h30;
  localparam logic [7:0]  CD_BLK  = 8'h50;
  localparam logic [7:0]  CD_CHIP = 8'h10;
  localparam logic [7:0]  CD_EXIT = 8'hF0;

endpackage

// File: rtl/fpoll_cmdseq.sv
module fpoll_cmdseq
  import fpoll_pkg::*;
#(
  parameter int AW = 19,
  parameter int DW = 16
) (
  input  logic          exit_sel,
  input  op_e           op,
  input  logic [2:0]    idx,
  input  logic [AW-1:0] tgt_addr,
  input  logic [DW-1:0] tgt_data,
  output logic [AW-1:0] seq_addr,
  output logic [DW-1:0] seq_data,
  output logic          seq_last
);

  localparam logic [AW-1:0] A1 = AW'(UNLK_A1);
  localparam logic [AW-1:0] A2 = AW'(UNLK_A2);

  always_comb begin
    seq_addr = A1;
    seq_data = DW'(CD_AA);
    seq_last = 1'b0;
    if (exit_sel) begin
      unique case (idx)
        3'd0:    begin seq_addr = A1; seq_data = DW'(CD_AA); end
        3'd1:    begin seq_addr = A2; seq_data = DW'(CD_55); end
        default: begin seq_addr = A1; seq_data = DW'(CD_EXIT); seq_last = 1'b1; end
      endcase
    end else begin
      unique case (idx)
        3'd0: begin seq_addr = A1; seq_data = DW'(CD_AA); end
        3'd1: begin seq_addr = A2; seq_data = DW'(CD_55); end
        3'd2: begin
          seq_addr = A1;
          seq_data = (op == OP_PROG) ? DW'(CD_PROG) : DW'(CD_ERS);
        end
        3'd3: begin
          if (op == OP_PROG) begin
            seq_addr = tgt_addr;
            seq_data = tgt_data;
            seq_last = 1'b1;
          end else begin
            seq_addr = A1;
            seq_data = DW'(CD_AA);
          end
        end
        3'd4: begin seq_addr = A2; seq_data = DW'(CD_55); end
        default: begin
          seq_last = 1'b1;
          unique case (op)
            OP_SECT: begin seq_addr = tgt_addr; seq_data = DW'(CD_SECT); end
            OP_BLK:  begin seq_addr = tgt_addr; seq_data = DW'(CD_BLK); end
            default: begin seq_addr = A1;       seq_data = DW'(CD_CHIP); end
          endcase
        end
      endcase
    end
  end

endmodule

// File: rtl/fpoll_judge.sv
module fpoll_judge #(
  parameter int DW = 16
) (
  input  logic          toggle_mode,
  input  logic          erase,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] rdata,
  input  logic          prev_b6,
  input  logic          prev_ok,
  output logic          complete,
  output logic          word_ok
);

  localparam int B7 = 7;
  localparam int B6 = 6;

  logic [DW-1:0] expect_w;
  logic          b7_done;
  logic          b6_done;

  assign expect_w = erase ? {DW{1'b1}} : wdata;
  assign b7_done  = erase ? rdata[B7] : (rdata[B7] == wdata[B7]);
  assign b6_done  = prev_ok && (rdata[B6] == prev_b6);
  assign complete = toggle_mode ? b6_done : b7_done;
  assign word_ok  = (rdata == expect_w);

endmodule

// File: rtl/fpoll_buscyc.sv
module fpoll_buscyc
  import fpoll_pkg::*;
#(
  parameter int AW   = 19,
  parameter int DW   = 16,
  parameter int T_SU = 1,
  parameter int T_PW = 2,
  parameter int T_HD = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] dq_in,
  output logic          ce_n,
  output logic          we_n,
  output logic          oe_n,
  output logic          dq_oe,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dq_o,
  output logic          done,
  output logic [DW-1:0] rdata
);

  localparam int TM1  = (T_SU > T_PW) ? T_SU : T_PW;
  localparam int TMAX = (TM1 > T_HD) ? TM1 : T_HD;
  localparam int CW   = (TMAX > 1) ? $clog2(TMAX) : 1;

  ph_e           ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] ph_lim;
  logic          ph_end;
  logic          done_q, done_d;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdat_q;
  logic [DW-1:0] rdat_q;
  logic          cap_en;
  logic          samp_en;

  always_comb begin
    unique case (ph_q)
      PH_SU:   ph_lim = CW'(T_SU - 1);
      PH_PW:   ph_lim = CW'(T_PW - 1);
      default: ph_lim = CW'(T_HD - 1);
    endcase
  end

  assign ph_end  = (cnt_q == ph_lim);
  assign cap_en  = start && (ph_q == PH_IDLE);
  assign samp_en = (ph_q == PH_PW) && ph_end && !wr_q;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d  = PH_SU;
          cnt_d = '0;
        end
      end
      PH_SU: begin
        if (ph_end) begin ph_d = PH_PW; cnt_d = '0; end
        else        cnt_d = cnt_q + 1'b1;
      end
      PH_PW: begin
        if (ph_end) begin ph_d = PH_HD; cnt_d = '0; end
        else        cnt_d = cnt_q + 1'b1;
      end
      default: begin
        if (ph_end) begin
          ph_d   = PH_IDLE;
          cnt_d  = '0;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      if (cap_en) begin
        wr_q   <= wr;
        addr_q <= addr;
        wdat_q <= wdata;
      end
      if (samp_en) rdat_q <= dq_in;
    end
  end

  assign ce_n   = (ph_q == PH_IDLE);
  assign we_n   = !((ph_q == PH_PW) && wr_q);
  assign oe_n   = !((ph_q == PH_PW) && !wr_q);
  assign dq_oe  = (ph_q != PH_IDLE) && wr_q;
  assign addr_o = addr_q;
  assign dq_o   = wdat_q;
  assign done   = done_q;
  assign rdata  = rdat_q;

endmodule

// File: rtl/fpoll_ctrl.sv
module fpoll_ctrl
  import fpoll_pkg::*;
#(
  parameter int AW        = 19,
  parameter int DW        = 16,
  parameter int T_SU      = 1,
  parameter int T_PW      = 2,
  parameter int T_HD      = 1,
  parameter int PROG_TMO  = 5000,
  parameter int ERASE_TMO = 5000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          req_toggle,
  output logic          done_o,
  output logic          err_o,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_in
);

  localparam int TMO_MAX = (PROG_TMO > ERASE_TMO) ? PROG_TMO : ERASE_TMO;
  localparam int TW      = $clog2(TMO_MAX + 1);

  st_e           st_q, st_d;
  logic [2:0]    idx_q, idx_d;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          tog_q;
  logic          lnch_q, lnch_d;
  logic          pb6_q, pb6_d;
  logic          pbv_q, pbv_d;
  logic          vbad_q, vbad_d;
  logic          vcnt_q, vcnt_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          done_q, done_d;
  logic          err_q, err_d;
  logic          ld_req;

  logic          is_erase;
  logic [TW-1:0] tmo_lim;
  logic          bus_act;
  logic          bus_wr;
  logic          bus_start;
  logic [AW-1:0] bus_addr;
  logic          bus_done;
  logic [DW-1:0] bus_rdata;
  logic [AW-1:0] seq_addr;
  logic [DW-1:0] seq_data;
  logic          seq_last;
  logic          st_done;
  logic          word_ok;
  logic          verify_bad;

  assign is_erase  = (op_q != OP_PROG);
  assign tmo_lim   = is_erase ? TW'(ERASE_TMO) : TW'(PROG_TMO);
  assign bus_act   = (st_q != ST_IDLE);
  assign bus_wr    = (st_q == ST_CMD) || (st_q == ST_EXIT);
  assign bus_start = bus_act && !lnch_q;
  assign bus_addr  = bus_wr ? seq_addr : addr_q;
  assign ld_req    = (st_q == ST_IDLE) && req_valid;
  assign verify_bad = vbad_q || !word_ok;

  fpoll_cmdseq #(.AW(AW), .DW(DW)) u_seq (
    .exit_sel (st_q == ST_EXIT),
    .op       (op_q),
    .idx      (idx_q),
    .tgt_addr (addr_q),
    .tgt_data (data_q),
    .seq_addr (seq_addr),
    .seq_data (seq_data),
    .seq_last (seq_last)
  );

  fpoll_judge #(.DW(DW)) u_judge (
    .toggle_mode (tog_q),
    .erase       (is_erase),
    .wdata       (data_q),
    .rdata       (bus_rdata),
    .prev_b6     (pb6_q),
    .prev_ok     (pbv_q),
    .complete    (st_done),
    .word_ok     (word_ok)
  );

  fpoll_buscyc #(
    .AW(AW), .DW(DW), .T_SU(T_SU), .T_PW(T_PW), .T_HD(T_HD)
  ) u_bus (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (bus_start),
    .wr     (bus_wr),
    .addr   (bus_addr),
    .wdata  (seq_data),
    .dq_in  (fl_dq_in),
    .ce_n   (fl_ce_n),
    .we_n   (fl_we_n),
    .oe_n   (fl_oe_n),
    .dq_oe  (fl_dq_oe),
    .addr_o (fl_addr),
    .dq_o   (fl_dq_out),
    .done   (bus_done),
    .rdata  (bus_rdata)
  );

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    lnch_d = lnch_q;
    pb6_d  = pb6_q;
    pbv_d  = pbv_q;
    vbad_d = vbad_q;
    vcnt_d = vcnt_q;
    tmr_d  = tmr_q;
    done_d = 1'b0;
    err_d  = 1'b0;
    if (bus_start) lnch_d = 1'b1;
    if (bus_done)  lnch_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          st_d   = ST_CMD;
          idx_d  = '0;
          lnch_d = 1'b0;
        end
      end
      ST_CMD: begin
        if (bus_done) begin
          if (seq_last) begin
            st_d  = ST_POLL;
            tmr_d = '0;
            pbv_d = 1'b0;
          end else begin
            idx_d = idx_q + 3'd1;
          end
        end
      end
      ST_POLL: begin
        if (tmr_q < tmo_lim) tmr_d = tmr_q + 1'b1;
        if (bus_done) begin
          pb6_d = bus_rdata[6];
          pbv_d = 1'b1;
          if (st_done) begin
            st_d   = ST_VERIFY;
            vcnt_d = 1'b0;
            vbad_d = 1'b0;
          end else if (tmr_q >= tmo_lim) begin
            st_d  = ST_EXIT;
            idx_d = '0;
            err_d = 1'b1;
          end
        end
      end
      ST_VERIFY: begin
        if (bus_done) begin
          if (vcnt_q) begin
            st_d   = ST_IDLE;
            done_d = !verify_bad;
            err_d  = verify_bad;
          end else begin
            vcnt_d = 1'b1;
            vbad_d = verify_bad;
          end
        end
      end
      default: begin
        if (bus_done) begin
          if (seq_last) st_d = ST_IDLE;
          else          idx_d = idx_q + 3'd1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      lnch_q <= 1'b0;
      pb6_q  <= 1'b0;
      pbv_q  <= 1'b0;
      vbad_q <= 1'b0;
      vcnt_q <= 1'b0;
      tmr_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      op_q   <= OP_PROG;
      addr_q <= '0;
      data_q <= '0;
      tog_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      lnch_q <= lnch_d;
      pb6_q  <= pb6_d;
      pbv_q  <= pbv_d;
      vbad_q <= vbad_d;
      vcnt_q <= vcnt_d;
      tmr_q  <= tmr_d;
      done_q <= done_d;
      err_q  <= err_d;
      if (ld_req) begin
        op_q   <= op_e'(req_op);
        addr_q <= req_addr;
        data_q <= req_data;
        tog_q  <= req_toggle;
      end
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;

endmodule

// File: rtl/fpoll_ctrl_chk.sv
module fpoll_ctrl_chk #(
  parameter int AW = 19,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          done_o,
  input logic          err_o,
  input logic          fl_ce_n,
  input logic          fl_we_n,
  input logic          fl_oe_n,
  input logic          fl_dq_oe,
  input logic [AW-1:0] fl_addr,
  input logic [DW-1:0] fl_dq_out
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!fl_we_n && !fl_oe_n)); // R7
  AST_STROBE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n) (!fl_we_n || !fl_oe_n) |-> !fl_ce_n); // R7
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n) !fl_oe_n |-> !fl_dq_oe); // R7
  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (!fl_ce_n && $past(!fl_ce_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out))); // R7
  AST_READY_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> fl_ce_n); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R9
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n) err_o |=> !err_o); // R9
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) !(done_o && err_o)); // R9

endmodule

bind fpoll_ctrl fpoll_ctrl_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .done_o    (done_o),
  .err_o     (err_o),
  .fl_ce_n   (fl_ce_n),
  .fl_we_n   (fl_we_n),
  .fl_oe_n   (fl_oe_n),
  .fl_dq_oe  (fl_dq_oe),
  .fl_addr   (fl_addr),
  .fl_dq_out (fl_dq_out)
);

// File: tb/fpoll_ctrl_tb_top.sv
`timescale 1ns/1ps
module fpoll_ctrl_tb_top;

  localparam int AW = 19;
  localparam int DW = 16;
  localparam int TSU = 1;
  localparam int TPW = 2;
  localparam int THD = 1;

  typedef struct packed {
    logic [1:0]  op;
    logic        tog;
    logic [18:0] addr;
    logic [15:0] data;
    logic [11:0] busy;
    logic [1:0]  kind;   // 0 clean, 1 one-shot race word, 2 stuck wrong word, 3 never finishes
  } vec_t;

  localparam vec_t VEC [0:10] = '{
    '{2'd0, 1'b0, 19'h12345, 16'h5A3C, 12'd60,  2'd0},
    '{2'd0, 1'b1, 19'h00F0F, 16'h00A5, 12'd80,  2'd0},
    '{2'd1, 1'b0, 19'h7F800, 16'h0000, 12'd200, 2'd0},
    '{2'd2, 1'b1, 19'h38000, 16'h0000, 12'd150, 2'd0},
    '{2'd3, 1'b0, 19'h00000, 16'h0000, 12'd300, 2'd0},
    '{2'd0, 1'b0, 19'h04444, 16'h8081, 12'd50,  2'd1},
    '{2'd1, 1'b1, 19'h01800, 16'h0000, 12'd120, 2'd1},
    '{2'd0, 1'b0, 19'h00123, 16'h0F0F, 12'd40,  2'd2},
    '{2'd3, 1'b1, 19'h00000, 16'h0000, 12'd90,  2'd2},
    '{2'd0, 1'b0, 19'h00456, 16'h1234, 12'd0,   2'd3},
    '{2'd2, 1'b1, 19'h08000, 16'h0000, 12'd0,   2'd3}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic          req_toggle;
  logic          done_o, err_o;
  logic          fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_dq_out;
  logic [DW-1:0] fl_dq_in;

  always #2 clk = ~clk;

  fpoll_ctrl #(
    .AW(AW), .DW(DW), .T_SU(TSU), .T_PW(TPW), .T_HD(THD),
    .PROG_TMO(400), .ERASE_TMO(1500)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_toggle(req_toggle),
    .done_o(done_o), .err_o(err_o), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in)
  );

  // flash model: configuration written only by the stimulus process
  logic        mdl_clr;
  int unsigned cfg_target;
  int unsigned cfg_busy;
  logic        cfg_prog, cfg_hang;
  logic [1:0]  cfg_kind;
  logic [15:0] cfg_data;

  // model state: written only by the model process
  logic [AW-1:0] log_a [0:15];
  logic [DW-1:0] log_d [0:15];
  int unsigned   wcnt, bcnt, we_run, oe_run, ce_run;
  logic          pwe, poe, pce, tgl, glitch_pend, busy_f, drv_bad, pw_bad;

  always @(posedge clk) begin
    pwe <= fl_we_n;
    poe <= fl_oe_n;
    pce <= fl_ce_n;
    we_run <= fl_we_n ? 0 : we_run + 1;
    oe_run <= fl_oe_n ? 0 : oe_run + 1;
    ce_run <= fl_ce_n ? 0 : ce_run + 1;
    if (mdl_clr) begin
      wcnt <= 0; busy_f <= 1'b0; bcnt <= 0; glitch_pend <= 1'b0;
      tgl <= 1'b0; drv_bad <= 1'b0; pw_bad <= 1'b0;
    end else begin
      if (!pwe && fl_we_n && we_run != TPW) pw_bad <= 1'b1;
      if (!poe && fl_oe_n && oe_run != TPW) pw_bad <= 1'b1;
      if (!pce && fl_ce_n && ce_run != TSU + TPW + THD) pw_bad <= 1'b1;
      if (!pwe && fl_we_n) begin
        if (wcnt < 16) begin
          log_a[wcnt] <= fl_addr;
          log_d[wcnt] <= fl_dq_out;
        end
        if (!fl_dq_oe) drv_bad <= 1'b1;
        wcnt <= wcnt + 1;
        if (wcnt + 1 == cfg_target) begin
          busy_f <= 1'b1;
          bcnt <= cfg_busy;
          glitch_pend <= (cfg_kind == 2'd1);
        end
      end else if (busy_f && !cfg_hang) begin
        if (bcnt <= 1) busy_f <= 1'b0;
        else bcnt <= bcnt - 1;
      end
      if (!poe && fl_oe_n) begin
        if (busy_f) tgl <= ~tgl;
        else glitch_pend <= 1'b0;
      end
    end
  end

  logic [15:0] fin_w;
  assign fin_w = cfg_prog ? cfg_data : 16'hFFFF;
  always_comb begin
    if (busy_f)             fl_dq_in = {8'h00, (cfg_prog ? ~cfg_data[7] : 1'b0), tgl, 6'h00};
    else if (glitch_pend)   fl_dq_in = fin_w ^ 16'h0101;
    else if (cfg_kind == 2) fl_dq_in = fin_w ^ 16'h0002;
    else                    fl_dq_in = fin_w;
  end

  int  nchk, nfail;
  bit  finished;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [34:0] last_op_write(input vec_t v);
    case (v.op)
      2'd0:    return {v.addr, v.data};
      2'd1:    return {v.addr, 16'h0030};
      2'd2:    return {v.addr, 16'h0050};
      default: return {19'h05555, 16'h0010};
    endcase
  endfunction

  task automatic run_op(input vec_t v, input bit overlap);
    int nd, ne, cyc, oplen, exp_wr;
    string otag;
    oplen  = (v.op == 2'd0) ? 4 : 6;
    exp_wr = oplen + ((v.kind == 2'd3) ? 3 : 0);
    otag   = (v.kind == 2'd3) ? "R6 outcome" : (v.kind != 2'd0) ? "R5 outcome" :
             v.tog ? "R4 outcome" : "R3 outcome";
    cfg_target = oplen; cfg_busy = v.busy; cfg_prog = (v.op == 2'd0);
    cfg_hang = (v.kind == 2'd3); cfg_kind = v.kind; cfg_data = v.data;
    mdl_clr = 1'b1;
    @(negedge clk);
    mdl_clr = 1'b0;
    chk(req_ready === 1'b1, "R8 ready before request", req_ready, 1);
    req_valid = 1'b1; req_op = v.op; req_addr = v.addr; req_data = v.data; req_toggle = v.tog;
    @(negedge clk);
    req_valid = 1'b0;
    nd = 0; ne = 0; cyc = 0;
    if (overlap) begin
      req_valid = 1'b1; req_op = 2'd3; req_addr = 19'h00777; req_data = 16'hBEEF;
      repeat (20) begin
        @(negedge clk);
        cyc++;
        chk(req_ready === 1'b0, "R8 busy while overlapped request", req_ready, 0);
        if (done_o) nd++;
        if (err_o) ne++;
      end
      req_valid = 1'b0;
    end
    while (!((nd + ne) > 0 && req_ready) && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (done_o) nd++;
      if (err_o) ne++;
    end
    repeat (3) begin
      @(negedge clk);
      if (done_o) nd++;
      if (err_o) ne++;
    end
    chk(ne == ((v.kind >= 2) ? 1 : 0), otag, ne, (v.kind >= 2) ? 1 : 0);
    chk(nd == ((v.kind >= 2) ? 0 : 1), "R9 done pulse count", nd, (v.kind >= 2) ? 0 : 1);
    chk(wcnt == exp_wr, (v.op == 2'd0) ? "R1 write count" : "R2 write count", wcnt, exp_wr);
    chk(log_a[0] == 19'h05555 && log_d[0] == 16'h00AA, "R1 first unlock write",
        {log_a[0][15:0], log_d[0]}, 32'h555500AA);
    chk(log_a[1] == 19'h02AAA && log_d[1] == 16'h0055, "R2 second unlock write",
        {log_a[1][15:0], log_d[1]}, 32'h2AAA0055);
    chk({log_a[oplen-1], log_d[oplen-1]} == last_op_write(v),
        (v.op == 2'd0) ? "R1 final program write" : "R2 final erase write",
        {log_a[oplen-1][15:0], log_d[oplen-1]}, last_op_write(v));
    if (v.kind == 2'd3)
      chk(log_a[8 - (v.op == 2'd0 ? 2 : 0)] == 19'h05555 && log_d[exp_wr-1] == 16'h00F0,
          "R6 exit write", {log_a[exp_wr-1][15:0], log_d[exp_wr-1]}, 32'h555500F0);
    chk(!drv_bad && !pw_bad, "R7 bus cycle shape", {drv_bad, pw_bad}, 0);
  endtask

  initial begin
    nchk = 0; nfail = 0; finished = 0;
    req_valid = 0; req_op = 0; req_addr = '0; req_data = '0; req_toggle = 0;
    cfg_target = 4; cfg_busy = 1; cfg_prog = 1; cfg_hang = 0; cfg_kind = 0; cfg_data = 0;
    mdl_clr = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && fl_ce_n === 1'b1 && fl_we_n === 1'b1 && fl_oe_n === 1'b1,
        "R10 strobes in reset", {req_ready, fl_ce_n, fl_we_n, fl_oe_n}, 4'hF);
    chk(done_o === 1'b0 && err_o === 1'b0 && fl_dq_oe === 1'b0, "R10 pulses in reset",
        {done_o, err_o, fl_dq_oe}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready === 1'b1 && fl_ce_n === 1'b1 && done_o === 1'b0 && err_o === 1'b0,
        "R10 state after reset", {req_ready, fl_ce_n, done_o, err_o}, 4'hC);
    mdl_clr = 1'b0;
    for (int i = 0; i < 11; i++) run_op(VEC[i], 1'b0);
    run_op(VEC[0], 1'b1);   // R8: request held during a busy operation
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog act=expired exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

endmodule